// File: doc/BRIEF.md
# PS/2 Host Receiver with Interrupt

This block is the host end of a two-wire keyboard/mouse style serial link for traffic from the device to the host. The device drives the clock and data lines. The block passes both lines through a two-flop synchroniser and a short glitch filter. It samples data on each falling clock edge and collects an 11-bit frame: a 0 start bit, eight data bits least significant bit first, an odd parity bit, and a 1 stop bit.

While the frame arrives, the block measures every clock low phase, every high phase and every full period against windows given in microseconds. A frame that passes all checks loads its byte into the data register and raises `irq`. A frame that fails any check produces a one-cycle `frame_err` pulse instead, and the byte is dropped.

While a byte waits unread, the block pulls the clock line low so that the device holds back its next frame. Software can also hold the line low through `inhibit_req`; doing so abandons any partly received frame. If a partly received frame stops with no clock edge for about 2 ms, the receiver drops it and returns to idle.

The controller has four states:
- IDLE waits for a start edge.
- LOW covers a clock low phase inside a frame.
- HIGH covers a clock high phase inside a frame.
- INHIB covers the time the host holds the clock low, and the wait until the line reads high again.

Its transitions are:
- IDLE→LOW on a falling edge.
- LOW→HIGH on a rising edge, for bits 1 to 10.
- LOW→IDLE on the rising edge that ends the stop bit (the frame is finished), or on timeout.
- HIGH→LOW on a falling edge.
- HIGH→IDLE on timeout.
- Any state→INHIB while the hold is active.
- INHIB→IDLE once the hold is released and the filtered clock reads high.

Top module: `ps2_host_rx`

## Requirements
- R1: A frame with start bit 0, eight data bits LSB first, parity bit making the count of ones in data plus parity odd, and stop bit 1, all phases in their windows, loads the byte into `rx_data` and raises `irq`. `rx_data` changes only when `irq` rises.
- R2: `irq` stays high until a cycle with `rd_ack` high, and is low in the cycle after that acknowledge.
- R3: While `irq` is high, `ps2_clk_drive` is high (the clock is held low). Once the byte is acknowledged and `inhibit_req` is low, `ps2_clk_drive` returns low.
- R4: `inhibit_req` high makes `ps2_clk_drive` high in the next cycle. A frame interrupted by the inhibit is dropped, so the next complete frame is received correctly.
- R5: A frame with wrong parity pulses `frame_err`, leaves `irq` low, and leaves `rx_data` unchanged.
- R6: A frame with start bit 1 or stop bit 0 pulses `frame_err` and raises no `irq`.
- R7: Each clock low phase must last from LO_MIN_US to LO_MAX_US microseconds, inclusive (TICKS_PER_US cycles per microsecond). Otherwise the frame is rejected as in R5.
- R8: Each high phase between two falling edges of a frame must last from HI_MIN_US to HI_MAX_US microseconds, inclusive. Otherwise the frame is rejected.
- R9: Each period, measured as a low phase plus the high phase that follows it, must lie from PER_MIN_US to PER_MAX_US microseconds, inclusive. Otherwise the frame is rejected.
- R10: A partial frame with no clock edge for TMO_US microseconds is dropped without a `frame_err` pulse, and the next frame is received correctly.
- R11: After reset, `irq`, `frame_err` and `ps2_clk_drive` are low and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Clock line as read from the wire |
| ps2_data_in | input | 1 | Data line as read from the wire |
| ps2_clk_drive | output | 1 | High to pull the clock line low (open drain) |
| inhibit_req | input | 1 | Software request to hold the device off |
| rd_ack | input | 1 | Pulse to mark the received byte as read |
| rx_data | output | 8 | Last valid received byte |
| irq | output | 1 | Interrupt request, high while a byte is unread |
| frame_err | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
The bench sweeps many byte values, including all zeros and all ones, with low and high phase lengths spread across their windows. It then sends frames exactly at each window bound and one cycle beyond it: a design with an off-by-one in the phase counter would reject an edge value, or accept the value just past it. It sends frames with a flipped parity bit, a 1 start bit and a 0 stop bit; a design that skipped any of these checks would raise `irq` and overwrite the stored byte. A frame cut off by a stall, and another cut off by an inhibit, each come before a clean frame; a receiver that did not drop the partial frame would shift the clean frame's bits out of line and deliver a wrong byte. The bench also checks that the hold on the clock tracks the unread byte and the inhibit request: a design that released it early would let the device overrun the data register.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_INHIB = 2'd3
    } rx_state_e;

    localparam int FRAME_BITS = 11;

    // data plus parity must carry an odd count of ones
    function automatic logic odd_ok(input logic [8:0] v);
        return ^v;
    endfunction
endpackage

// File: rtl/ps2rx_filter.sv
module ps2rx_filter #(
    parameter int   FILT_LEN  = 3,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [FW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= RESET_VAL;
            s2   <= RESET_VAL;
            filt <= RESET_VAL;
            run  <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 != filt) begin
                if (run == FW'(FILT_LEN - 1)) begin
                    filt <= s2;
                    run  <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/ps2rx_phase.sv
module ps2rx_phase #(
    parameter int TICKS_PER_US = 50,
    parameter int LO_MIN_US    = 25,
    parameter int LO_MAX_US    = 55,
    parameter int HI_MIN_US    = 25,
    parameter int HI_MAX_US    = 45,
    parameter int PER_MIN_US   = 55,
    parameter int PER_MAX_US   = 85,
    parameter int TMO_US       = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    output logic lo_ok,
    output logic hi_ok,
    output logic per_ok,
    output logic tmo
);
    localparam int TMO_CYC = TMO_US * TICKS_PER_US;
    localparam int CW      = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LO_MIN_C  = CW'(LO_MIN_US * TICKS_PER_US);
    localparam logic [CW-1:0] LO_MAX_C  = CW'(LO_MAX_US * TICKS_PER_US);
    localparam logic [CW-1:0] HI_MIN_C  = CW'(HI_MIN_US * TICKS_PER_US);
    localparam logic [CW-1:0] HI_MAX_C  = CW'(HI_MAX_US * TICKS_PER_US);
    localparam logic [CW:0]   PER_MIN_C = (CW+1)'(PER_MIN_US * TICKS_PER_US);
    localparam logic [CW:0]   PER_MAX_C = (CW+1)'(PER_MAX_US * TICKS_PER_US);
    localparam logic [CW-1:0] TMO_C     = CW'(TMO_CYC);

    logic [CW-1:0] cnt;     // cycles since the last edge
    logic [CW-1:0] lo_len;  // length of the last low phase
    logic [CW:0]   per_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= TMO_C;
            lo_len <= '0;
        end else begin
            if (rise || fall) cnt <= CW'(1);
            else if (cnt != TMO_C) cnt <= cnt + 1'b1;
            if (rise) lo_len <= cnt;
        end
    end

    assign per_len = {1'b0, lo_len} + {1'b0, cnt};
    assign lo_ok   = (cnt >= LO_MIN_C) && (cnt <= LO_MAX_C);
    assign hi_ok   = (cnt >= HI_MIN_C) && (cnt <= HI_MAX_C);
    assign per_ok  = (per_len >= PER_MIN_C) && (per_len <= PER_MAX_C);
    assign tmo     = (cnt == TMO_C);
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
    parameter int TICKS_PER_US = 50,
    parameter int FILT_LEN     = 3,
    parameter int LO_MIN_US    = 25,
    parameter int LO_MAX_US    = 55,
    parameter int HI_MIN_US    = 25,
    parameter int HI_MAX_US    = 45,
    parameter int PER_MIN_US   = 55,
    parameter int PER_MAX_US   = 85,
    parameter int TMO_US       = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_in,
    input  logic       ps2_data_in,
    output logic       ps2_clk_drive,
    input  logic       inhibit_req,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       irq,
    output logic       frame_err
);
    import ps2rx_pkg::*;

    localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS);

    rx_state_e  state, state_nx;
    logic       clk_f, data_f, clk_prev;
    logic       rise, fall;
    logic       lo_ok, hi_ok, per_ok, tmo;
    logic       pending, inh_q, hold;
    logic       bad;
    logic [3:0] bit_cnt;
    logic [9:0] sh;

    ps2rx_filter #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_clk_filt (
        .clk(clk), .rst_n(rst_n), .raw(ps2_clk_in), .filt(clk_f));
    ps2rx_filter #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_dat_filt (
        .clk(clk), .rst_n(rst_n), .raw(ps2_data_in), .filt(data_f));

    ps2rx_phase #(
        .TICKS_PER_US(TICKS_PER_US),
        .LO_MIN_US(LO_MIN_US), .LO_MAX_US(LO_MAX_US),
        .HI_MIN_US(HI_MIN_US), .HI_MAX_US(HI_MAX_US),
        .PER_MIN_US(PER_MIN_US), .PER_MAX_US(PER_MAX_US),
        .TMO_US(TMO_US)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .lo_ok(lo_ok), .hi_ok(hi_ok), .per_ok(per_ok), .tmo(tmo));

    assign rise          = clk_f & ~clk_prev;
    assign fall          = ~clk_f & clk_prev;
    assign hold          = pending | inh_q;
    assign ps2_clk_drive = hold;
    assign irq           = pending;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hold)      state_nx = ST_INHIB;
                else if (fall) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (hold)      state_nx = ST_INHIB;
                else if (tmo)  state_nx = ST_IDLE;
                else if (rise) state_nx = (bit_cnt == LAST_BIT) ? ST_IDLE : ST_HIGH;
            end
            ST_HIGH: begin
                if (hold)      state_nx = ST_INHIB;
                else if (tmo)  state_nx = ST_IDLE;
                else if (fall) state_nx = ST_LOW;
            end
            ST_INHIB: begin
                if (!hold && clk_f) state_nx = ST_IDLE;
            end
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev  <= 1'b1;
            inh_q     <= 1'b0;
            pending   <= 1'b0;
            rx_data   <= '0;
            frame_err <= 1'b0;
            bad       <= 1'b0;
            bit_cnt   <= '0;
            sh        <= '0;
        end else begin
            clk_prev  <= clk_f;
            inh_q     <= inhibit_req;
            frame_err <= 1'b0;
            if (rd_ack) pending <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (!hold && fall) begin
                        bad     <= data_f;      // start bit must be 0
                        bit_cnt <= 4'd1;
                    end
                end
                ST_LOW: begin
                    if (!hold && !tmo && rise) begin
                        if (bit_cnt == LAST_BIT) begin
                            if (bad || !lo_ok || !sh[9] || !odd_ok(sh[8:0])) begin
                                frame_err <= 1'b1;
                            end else begin
                                rx_data <= sh[7:0];
                                pending <= 1'b1;
                            end
                        end else begin
                            bad <= bad | ~lo_ok;
                        end
                    end
                end
                ST_HIGH: begin
                    if (!hold && !tmo && fall) begin
                        sh      <= {data_f, sh[9:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                        bad     <= bad | ~hi_ok | ~per_ok;
                    end
                end
                ST_INHIB: ;
            endcase
        end
    end
endmodule

// File: rtl/ps2rx_checker.sv
module ps2rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit_req,
    input logic       rd_ack,
    input logic       ps2_clk_drive,
    input logic [7:0] rx_data,
    input logic       irq,
    input logic       frame_err
);
    assert_irq_holds_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ps2_clk_drive);

    assert_line_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !$past(inhibit_req)) |-> !ps2_clk_drive);

    assert_irq_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_ack) |=> irq);

    assert_irq_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd_ack) |=> !irq);

    assert_inhibit_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_req |=> ps2_clk_drive);

    assert_err_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !irq);

    assert_data_on_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(irq) |-> $stable(rx_data));
endmodule

bind ps2_host_rx ps2rx_checker u_ps2rx_checker (
    .clk(clk), .rst_n(rst_n), .inhibit_req(inhibit_req), .rd_ack(rd_ack),
    .ps2_clk_drive(ps2_clk_drive), .rx_data(rx_data), .irq(irq),
    .frame_err(frame_err));

// File: tb/test_ps2_host_rx.sv
module test_ps2_host_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_clk = 1'b1;
    logic       dev_data = 1'b1;
    logic       inhibit_req = 1'b0;
    logic       rd_ack = 1'b0;
    logic       ps2_clk_drive;
    logic [7:0] rx_data;
    logic       irq;
    logic       frame_err;
    wire        line_clk = dev_clk & ~ps2_clk_drive;

    int total = 0;
    int fails = 0;
    int err_seen = 0;
    logic [7:0] last_good = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // bench windows in cycles (2 cycles per microsecond)
    ps2_host_rx #(.TICKS_PER_US(2)) i_ps2_host_rx (
        .clk(clk), .rst_n(rst_n), .ps2_clk_in(line_clk), .ps2_data_in(dev_data),
        .ps2_clk_drive(ps2_clk_drive), .inhibit_req(inhibit_req), .rd_ack(rd_ack),
        .rx_data(rx_data), .irq(irq), .frame_err(frame_err));

    always @(posedge clk) if (frame_err) err_seen <= err_seen + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input logic [7:0] b, input bit pflip,
                                       input bit st, input bit sp);
        return {sp, (~^b) ^ pflip, b, st};
    endfunction

    task automatic dev_send(input logic [10:0] bits, input int lo, input int hi, input int n);
        for (int i = 0; i < n; i++) begin
            dev_data = bits[i];
            repeat (hi) @(negedge clk);
            dev_clk = 1'b0;
            repeat (lo) @(negedge clk);
            dev_clk = 1'b1;
        end
        repeat (hi) @(negedge clk);
        dev_data = 1'b1;
    endtask

    task automatic ack_and_check(input string tag);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        repeat (10) @(negedge clk);
        check(irq == 1'b0, {tag, " R2 irq cleared by ack"}, irq, 0);
        check(ps2_clk_drive == 1'b0, {tag, " R3 line released"}, ps2_clk_drive, 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic expect_good(input logic [7:0] b, input int lo, input int hi, input string tag);
        int e0;
        e0 = err_seen;
        dev_send(mk(b, 1'b0, 1'b0, 1'b1), lo, hi, 11);
        check(irq == 1'b1, {tag, " irq raised"}, irq, 1);
        check(rx_data == b, {tag, " data"}, rx_data, b);
        check(err_seen == e0, {tag, " no error"}, err_seen, e0);
        check(ps2_clk_drive == 1'b1, {tag, " R3 line held while pending"}, ps2_clk_drive, 1);
        last_good = b;
        ack_and_check(tag);
    endtask

    task automatic expect_bad(input logic [10:0] bits, input int lo, input int hi, input string tag);
        int e0;
        e0 = err_seen;
        dev_send(bits, lo, hi, 11);
        check(err_seen == e0 + 1, {tag, " error pulse"}, err_seen, e0 + 1);
        check(irq == 1'b0, {tag, " no irq"}, irq, 0);
        check(rx_data == last_good, {tag, " data kept"}, rx_data, last_good);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        check(irq == 1'b0, "R11 irq", irq, 0);
        check(frame_err == 1'b0, "R11 frame_err", frame_err, 0);
        check(ps2_clk_drive == 1'b0, "R11 drive", ps2_clk_drive, 0);
        check(rx_data == 8'h00, "R11 data", rx_data, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1 sweep of byte values and phase lengths
        for (int k = 0; k < 40; k++) begin
            logic [7:0] b;
            int lo, hi;
            b  = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37 + 11) & 255);
            lo = 50 + (k * 7) % 61;
            hi = 50 + (k * 3) % 41;
            if (lo + hi > 170) hi = 170 - lo;
            if (lo + hi < 110) hi = 110 - lo;
            expect_good(b, lo, hi, "R1 sweep");
        end

        // R5 parity, R6 start and stop
        expect_bad(mk(8'hA5, 1'b1, 1'b0, 1'b1), 60, 60, "R5 parity");
        expect_bad(mk(8'h3C, 1'b0, 1'b1, 1'b1), 60, 60, "R6 start");
        expect_bad(mk(8'h3C, 1'b0, 1'b0, 1'b0), 60, 60, "R6 stop");

        // R7 low phase bounds
        expect_good(8'h11, 50, 60, "R7 low min");
        expect_bad(mk(8'h22, 1'b0, 1'b0, 1'b1), 49, 61, "R7 low short");
        expect_good(8'h33, 110, 60, "R7 low max");
        expect_bad(mk(8'h44, 1'b0, 1'b0, 1'b1), 111, 55, "R7 low long");
        // R8 high phase bounds
        expect_good(8'h55, 60, 50, "R8 high min");
        expect_bad(mk(8'h66, 1'b0, 1'b0, 1'b1), 61, 49, "R8 high short");
        expect_good(8'h77, 80, 90, "R8 high max");
        expect_bad(mk(8'h88, 1'b0, 1'b0, 1'b1), 70, 91, "R8 high long");
        // R9 period bounds
        expect_good(8'h99, 55, 55, "R9 period min");
        expect_bad(mk(8'hAA, 1'b0, 1'b0, 1'b1), 55, 54, "R9 period short");
        expect_bad(mk(8'hBB, 1'b0, 1'b0, 1'b1), 110, 61, "R9 period long");

        // R10 stalled partial frame then clean frame
        begin
            int e0;
            e0 = err_seen;
            dev_send(mk(8'hF0, 1'b0, 1'b0, 1'b1), 60, 60, 5);
            repeat (4200) @(negedge clk);
            check(err_seen == e0, "R10 silent drop", err_seen, e0);
            check(irq == 1'b0, "R10 no irq", irq, 0);
            expect_good(8'h5A, 60, 60, "R10 after timeout");
        end

        // R4 inhibit mid-frame
        dev_send(mk(8'h0F, 1'b0, 1'b0, 1'b1), 60, 60, 4);
        inhibit_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(ps2_clk_drive == 1'b1, "R4 drive on inhibit", ps2_clk_drive, 1);
        repeat (50) @(negedge clk);
        check(ps2_clk_drive == 1'b1, "R4 drive held", ps2_clk_drive, 1);
        inhibit_req = 1'b0;
        repeat (20) @(negedge clk);
        check(ps2_clk_drive == 1'b0, "R4 drive released", ps2_clk_drive, 0);
        expect_good(8'hC3, 70, 70, "R4 after inhibit");

        // R2/R3 long pending hold
        dev_send(mk(8'h6E, 1'b0, 1'b0, 1'b1), 60, 60, 11);
        repeat (3000) @(negedge clk);
        check(irq == 1'b1, "R2 irq held without ack", irq, 1);
        check(ps2_clk_drive == 1'b1, "R3 line held long", ps2_clk_drive, 1);
        check(rx_data == 8'h6E, "R1 data held", rx_data, 8'h6E);
        ack_and_check("R2 long");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule